// File: doc/BRIEF.md
# Frame-Counting Ring Buffer FIFO

This block is a byte-wide ring buffer for framed serial data. Beside the usual write and read byte pointers, it keeps a second pair of wrapping counters that count whole frames: one advances when the writer closes a frame, the other when the reader reports that it has consumed a frame. From these the block derives an empty flag and a frame-available flag. A reader that only wants complete frames can therefore wait on frame-available instead of tracking byte counts.

The four counters are the byte write pointer, the byte read pointer, the frames-stored count and the frames-read count. A small host register port reads and overwrites each of them, so software can reposition the ring, skip data or discard frames. A hardware reset or a one-cycle software reset sets every counter to all ones. One parameter selects the counter widths for a wide data channel or a narrow signalling channel. Storage is an internal RAM whose size is set by the byte-pointer width.

Top module: `frame_ring_fifo`

## Requirements
- R1: An accepted write stores `wr_data` at the write pointer, which then advances by one. An accepted read takes the byte at the read pointer, which then advances by one. That byte appears on `rd_data`, with `rd_valid` high, in the cycle after the read, and bytes come out in the order they were written.
- R2: `empty` is high exactly when the write pointer equals the read pointer.
- R3: A write while the write pointer plus one equals the read pointer is refused. The write pointer keeps its value and the sticky `overflow` flag is set.
- R4: A read while `empty` is high is refused. The read pointer keeps its value, `rd_valid` stays low and the sticky `underflow` flag is set.
- R5: The frames-stored counter advances on an accepted write that has `wr_eof` high. `frame_avail` is high exactly when the frames-stored and frames-read counters differ.
- R6: An accepted read with `rd_frame_done` high advances the frames-read counter only while `frame_avail` is high. If `frame_avail` is low, the counter keeps its value and the sticky `frame_err` flag is set.
- R7: With `D_CHANNEL`=1 the byte pointers are 9 bits and the frame counters 4 bits. With `D_CHANNEL`=0 they are 13 and 5 bits. Every counter wraps modulo 2 to the power of its width.
- R8: Hardware reset, and a `sw_rst` pulse on the next clock edge, set all four counters to all ones and clear the three sticky flags and `rd_valid`. `sw_rst` takes priority over any write, read or host write in the same cycle.
- R9: `host_sel` selects a counter: 0 is the write pointer, 1 the read pointer, 2 the frames-stored counter and 3 the frames-read counter. `host_rdata` shows the selected counter, zero-extended, in the same cycle. With `host_we` high, the low bits of `host_wdata` are loaded into the selected counter at the clock edge.
- R10: A host write to a counter takes priority over a data-path increment of the same counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Single-cycle software reset request |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to store |
| wr_eof | input | 1 | The written byte ends a frame |
| rd_en | input | 1 | Read request |
| rd_frame_done | input | 1 | This read completes a frame |
| rd_data | output | 8 | Byte read out, valid with rd_valid |
| rd_valid | output | 1 | rd_data holds the byte of last cycle's accepted read |
| empty | output | 1 | Byte pointers are equal |
| frame_avail | output | 1 | At least one complete frame is stored |
| overflow | output | 1 | Sticky: a write was refused |
| underflow | output | 1 | Sticky: a read was refused |
| frame_err | output | 1 | Sticky: frame done reported with no frame stored |
| host_we | input | 1 | Host counter write strobe |
| host_sel | input | 2 | Counter select for host read and write |
| host_wdata | input | 16 | Host counter write value |
| host_rdata | output | 16 | Selected counter, zero-extended |

## Verification
A wrong pointer shows up at the ports one cycle after the bad update. `empty` or `frame_avail` switches at the wrong time, and the next accepted read returns a byte out of order. A corrupted frame counter shows up as `frame_avail` staying high or low wrongly, or as a spurious `frame_err` on the next frame-done read. Every counter is also read back directly through the host port in the same cycle. The bench therefore compares the exact counter values after wrap-around, after host loads and after both kinds of reset.

// File: rtl/frame_fifo_pkg.sv
package frame_fifo_pkg;

    typedef enum logic [1:0] {
        SEL_WPTR  = 2'd0,
        SEL_RPTR  = 2'd1,
        SEL_FSTOR = 2'd2,
        SEL_FREAD = 2'd3
    } cnt_sel_e;

    typedef struct packed {
        logic ovf;
        logic udf;
        logic ferr;
        logic rvalid;
    } stat_t;

    function automatic int unsigned byte_ptr_w(input bit narrow);
        return narrow ? 9 : 13;
    endfunction

    function automatic int unsigned frame_cnt_w(input bit narrow);
        return narrow ? 4 : 5;
    endfunction

endpackage

// File: rtl/frame_fifo_ctr.sv
module frame_fifo_ctr #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '1;
        end else if (ld) begin
            cnt_d = ld_val;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign q = cnt_q;
endmodule

// File: rtl/frame_fifo_ram.sv
module frame_fifo_ram #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/frame_ring_fifo.sv
module frame_ring_fifo
    import frame_fifo_pkg::*;
#(
    parameter bit          D_CHANNEL = 1'b1,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned HOST_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    input  logic              rd_en,
    input  logic              rd_frame_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              frame_avail,
    output logic              overflow,
    output logic              underflow,
    output logic              frame_err,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata
);
    localparam int unsigned ZW = byte_ptr_w(D_CHANNEL);
    localparam int unsigned FW = frame_cnt_w(D_CHANNEL);

    logic [ZW-1:0] wptr, rptr, wptr_nx;
    logic [FW-1:0] fstor, fread;
    logic          full, is_empty, has_frame;
    logic          wr_ok, rd_ok, fread_inc, fstor_inc;
    logic          ld_wptr, ld_rptr, ld_fstor, ld_fread;
    cnt_sel_e      sel;
    stat_t         st_d, st_q;
    logic          unused_host_hi;

    assign sel            = cnt_sel_e'(host_sel);
    assign unused_host_hi = ^host_wdata[HOST_W-1:ZW];

    assign wptr_nx   = wptr + 1'b1;
    assign full      = (wptr_nx == rptr);
    assign is_empty  = (wptr == rptr);
    assign has_frame = (fstor != fread);

    assign wr_ok     = wr_en && !full && !sw_rst;
    assign rd_ok     = rd_en && !is_empty && !sw_rst;
    assign fstor_inc = wr_ok && wr_eof;
    assign fread_inc = rd_ok && rd_frame_done && has_frame;

    assign ld_wptr  = host_we && (sel == SEL_WPTR);
    assign ld_rptr  = host_we && (sel == SEL_RPTR);
    assign ld_fstor = host_we && (sel == SEL_FSTOR);
    assign ld_fread = host_we && (sel == SEL_FREAD);

    frame_fifo_ctr #(.W(ZW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst), .inc(wr_ok),
        .ld(ld_wptr), .ld_val(host_wdata[ZW-1:0]), .q(wptr)
    );
    frame_fifo_ctr #(.W(ZW)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst), .inc(rd_ok),
        .ld(ld_rptr), .ld_val(host_wdata[ZW-1:0]), .q(rptr)
    );
    frame_fifo_ctr #(.W(FW)) u_fstor (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst), .inc(fstor_inc),
        .ld(ld_fstor), .ld_val(host_wdata[FW-1:0]), .q(fstor)
    );
    frame_fifo_ctr #(.W(FW)) u_fread (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst), .inc(fread_inc),
        .ld(ld_fread), .ld_val(host_wdata[FW-1:0]), .q(fread)
    );

    frame_fifo_ram #(.AW(ZW), .DW(DATA_W)) u_ram (
        .clk(clk), .we(wr_ok), .waddr(wptr), .wdata(wr_data),
        .re(rd_ok), .raddr(rptr), .rdata(rd_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_ok;
        if (wr_en && full) begin
            st_d.ovf = 1'b1;
        end
        if (rd_en && is_empty) begin
            st_d.udf = 1'b1;
        end
        if (rd_ok && rd_frame_done && !has_frame) begin
            st_d.ferr = 1'b1;
        end
        if (sw_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_WPTR:  host_rdata = {{(HOST_W-ZW){1'b0}}, wptr};
            SEL_RPTR:  host_rdata = {{(HOST_W-ZW){1'b0}}, rptr};
            SEL_FSTOR: host_rdata = {{(HOST_W-FW){1'b0}}, fstor};
            default:   host_rdata = {{(HOST_W-FW){1'b0}}, fread};
        endcase
    end

    assign rd_valid    = st_q.rvalid;
    assign empty       = is_empty;
    assign frame_avail = has_frame;
    assign overflow    = st_q.ovf;
    assign underflow   = st_q.udf;
    assign frame_err   = st_q.ferr;
endmodule

// File: rtl/frame_fifo_chk.sv
module frame_fifo_chk #(
    parameter int unsigned ZW     = 9,
    parameter int unsigned FW     = 4,
    parameter int unsigned HOST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_frame_done,
    input logic              host_we,
    input logic [1:0]        host_sel,
    input logic [HOST_W-1:0] host_wdata,
    input logic [ZW-1:0]     wptr,
    input logic [ZW-1:0]     rptr,
    input logic [FW-1:0]     fread,
    input logic              full,
    input logic              empty,
    input logic              frame_avail,
    input logic              overflow,
    input logic              underflow,
    input logic              frame_err,
    input logic              rd_valid
);
    // R2
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !rd_en && !sw_rst && !host_we) |=> !empty);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !sw_rst && !host_we) |=> (overflow && $stable(wptr)));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !sw_rst && !host_we) |=> (underflow && !rd_valid && $stable(rptr)));

    // R6
    orphan_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty && rd_frame_done && !frame_avail && !sw_rst && !host_we)
        |=> (frame_err && $stable(fread)));

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (empty && !frame_avail && (&wptr) && !overflow && !underflow && !frame_err));

    // R10
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !sw_rst && host_sel == 2'd0) |=> (wptr == $past(host_wdata[ZW-1:0])));
endmodule

bind frame_ring_fifo frame_fifo_chk #(.ZW(ZW), .FW(FW), .HOST_W(HOST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en), .rd_en(rd_en),
    .rd_frame_done(rd_frame_done), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .wptr(wptr), .rptr(rptr), .fread(fread),
    .full(full), .empty(empty), .frame_avail(frame_avail), .overflow(overflow),
    .underflow(underflow), .frame_err(frame_err), .rd_valid(rd_valid)
);

// File: tb/frame_ring_fifo_test.sv
module frame_ring_fifo_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       wr;
        logic       eof;
        logic [7:0] din;
        logic       rd;
        logic       fd;
        logic       e_empty;
        logic       e_favail;
        logic       e_rdv;
        logic [7:0] e_dout;
    } vec_t;

    // Vectors from reset; the pointers start at all ones and wrap (R1 R2 R4 R5 R6 R7)
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA1},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA2},
        '{1'b1, 1'b1, 8'hB1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'hB2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hB1},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hB2},
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_eof = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_frame_done = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, empty, frame_avail, overflow, underflow, frame_err;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    frame_ring_fifo uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eof(wr_eof), .rd_en(rd_en), .rd_frame_done(rd_frame_done),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .frame_avail(frame_avail),
        .overflow(overflow), .underflow(underflow), .frame_err(frame_err),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_eof = 1'b0; rd_en = 1'b0; rd_frame_done = 1'b0;
        host_we = 1'b0; sw_rst = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [15:0] val);
        host_sel = sel;
        #1;
        val = host_rdata;
    endtask

    task automatic soft_reset();
        idle();
        sw_rst = 1'b1;
        tick();
        sw_rst = 1'b0;
    endtask

    task automatic host_load(input logic [1:0] sel, input logic [15:0] val);
        idle();
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        tick();
        host_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        @(negedge clk);
        @(negedge clk);
        // R8 hardware reset state (R9 selects: 0 wptr, 1 rptr, 2 stored, 3 read)
        peek(2'd0, v); check("R8 wptr at reset", v, 16'h01FF);
        peek(2'd1, v); check("R8 rptr at reset", v, 16'h01FF);
        peek(2'd2, v); check("R8 fstor at reset", v, 16'h000F);
        peek(2'd3, v); check("R8 fread at reset", v, 16'h000F);
        check("R2 empty at reset", empty, 1);
        check("R5 frame_avail at reset", frame_avail, 0);
        check("R8 flags at reset", {overflow, underflow, frame_err, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        foreach (VECS[i]) begin
            wr_en = VECS[i].wr; wr_eof = VECS[i].eof; wr_data = VECS[i].din;
            rd_en = VECS[i].rd; rd_frame_done = VECS[i].fd;
            tick();
            check($sformatf("R2 empty vec %0d", i), empty, VECS[i].e_empty);
            check($sformatf("R5 frame_avail vec %0d", i), frame_avail, VECS[i].e_favail);
            check($sformatf("R1 rd_valid vec %0d", i), rd_valid, VECS[i].e_rdv);
            if (VECS[i].e_rdv) begin
                check($sformatf("R1 rd_data vec %0d", i), rd_data, VECS[i].e_dout);
            end
        end
        idle();
        // R7 wrap: 4 writes from 1FF gives 3; 2 frames from F gives 1
        peek(2'd0, v); check("R7 wptr wrapped", v, 16'h0003);
        peek(2'd1, v); check("R7 rptr wrapped", v, 16'h0003);
        peek(2'd2, v); check("R7 fstor wrapped", v, 16'h0001);
        peek(2'd3, v); check("R6 fread after done", v, 16'h0001);
        check("R4 underflow sticky", underflow, 1);
        check("R3 no overflow yet", overflow, 0);
        check("R6 no frame_err yet", frame_err, 0);

        // R8 software reset clears
        soft_reset();
        peek(2'd0, v); check("R8 wptr after sw_rst", v, 16'h01FF);
        peek(2'd3, v); check("R8 fread after sw_rst", v, 16'h000F);
        check("R8 underflow cleared", underflow, 0);

        // R6 frame done with no frame stored
        idle(); wr_en = 1'b1; wr_data = 8'h5C; wr_eof = 1'b0;
        tick();
        idle(); rd_en = 1'b1; rd_frame_done = 1'b1;
        tick();
        idle();
        check("R6 frame_err set", frame_err, 1);
        check("R1 rd_data 5C", rd_data, 8'h5C);
        peek(2'd3, v); check("R6 fread held", v, 16'h000F);

        // R3 overflow via host-positioned pointer (R9 load)
        soft_reset();
        host_load(2'd0, 16'h01FE);
        peek(2'd0, v); check("R9 host load wptr", v, 16'h01FE);
        check("R2 not empty after load", empty, 0);
        idle(); wr_en = 1'b1; wr_data = 8'h77;
        tick();
        idle();
        check("R3 overflow set", overflow, 1);
        peek(2'd0, v); check("R3 wptr held", v, 16'h01FE);

        // R8 sw_rst wins over simultaneous write and read
        idle(); sw_rst = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
        tick();
        idle();
        peek(2'd0, v); check("R8 sw_rst beats write", v, 16'h01FF);
        check("R8 empty after sw_rst", empty, 1);
        check("R8 overflow cleared", overflow, 0);
        check("R8 no rd_valid", rd_valid, 0);

        // R10 host write beats a write increment
        idle(); wr_en = 1'b1; wr_data = 8'h11; wr_eof = 1'b1;
        host_we = 1'b1; host_sel = 2'd0; host_wdata = 16'h0007;
        tick();
        idle();
        peek(2'd0, v); check("R10 host load wins", v, 16'h0007);
        peek(2'd2, v); check("R5 fstor counted eof", v, 16'h0000);
        check("R5 frame_avail after eof", frame_avail, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule